// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block sits next to a processor core and decides which event the core services next. Sixteen request lines, numbered 0 to 15, feed it, and a lower number means a more urgent event. Levels 0 to 6 have fixed jobs: emulation, reset, non-maskable interrupt, exception, global enable, hardware error and core timer. Levels 7 to 15 are nine general-purpose interrupt inputs.

A rising edge on a request line latches that level as pending. A pending level that is enabled in the mask is granted only if it is strictly more urgent than every level now in service. A grant raises a one-cycle take strobe with the level number and its vector index. The granted level moves from pending to active. A return pulse retires the most urgent active level, which resumes whatever it preempted.

Because several levels can be active at once, a long low-priority service can be interrupted and later resumed. Levels 0 to 4 cannot be masked, and this includes the non-maskable level 2.

Top module: `evt_nest_ctrl`

## Requirements
- R1: While rst is high on a clock edge, pend_o becomes 16'h0002 (level 1 pending), act_o becomes 0 and take_o becomes 0. After that edge, levels 5 to 15 are disabled and levels 0 to 4 are enabled.
- R2: A rising edge of req_i[n], seen as low on one clock edge and high on the next, sets pend_o[n] at the later edge. Holding req_i[n] high does not set it again.
- R3: When several pending levels are enabled, the lowest-numbered one is granted first.
- R4: A pending level that is disabled stays in pend_o and is never taken. Once a mask write enables it, it is taken on the edge after the write edge.
- R5: A mask write (mask_wr_i high with mask_i, where bit n = 1 enables level n) cannot disable levels 0 to 4. The non-maskable level 2 is always taken when it is eligible.
- R6: A level is granted only if its number is strictly lower than every bit set in act_o. A pending level whose number is equal to or higher than an active level waits.
- R7: A grant takes effect on the clock edge after the level became pending and enabled. On that edge take_o is high for one cycle, take_lvl_o is the level, vec_o is VEC_BASE + level*VEC_STRIDE (defaults 8'h40 and 4), the pend_o bit clears and the act_o bit sets.
- R8: A return pulse (ret_i high on an edge) clears the lowest-numbered set bit of act_o, so the preempted level becomes the most urgent active level again.
- R9: A return pulse while act_o is zero leaves act_o and pend_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Event request lines, one per level |
| mask_wr_i | input | 1 | Loads mask_i into the level enable register |
| mask_i | input | 16 | Level enables; bit n = 1 enables level n |
| ret_i | input | 1 | Return-from-service pulse |
| take_o | output | 1 | One-cycle strobe: a level was granted |
| take_lvl_o | output | 4 | Number of the granted level |
| vec_o | output | 8 | Vector index of the granted level |
| pend_o | output | 16 | Latched pending levels |
| act_o | output | 16 | Levels currently in service |

## Verification
The assertions check four rules on every cycle. Every take names a level that was pending and enabled on the previous cycle. That level was strictly more urgent than everything then active, and it shows as active. A return retires exactly one active level, and a return with nothing active changes nothing. The bench scenarios show the rest: the exact reset values, which of two simultaneous requests wins, nested preempt-and-resume sequences, that a held request is latched only once, and that levels 0 to 4 survive a mask write of all zeros.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int unsigned NLVL  = 16;
    localparam int unsigned LVL_W = $clog2(NLVL);

    typedef logic [NLVL-1:0] lvl_vec_t;

    typedef enum logic [LVL_W-1:0] {
        LV_EMU = 4'd0,
        LV_RST = 4'd1,
        LV_NMI = 4'd2,
        LV_EXC = 4'd3,
        LV_GEN = 4'd4,
        LV_HWE = 4'd5,
        LV_TMR = 4'd6,
        LV_GP0 = 4'd7
    } lvl_name_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] idx;
    } pick_t;

    // lowest-numbered set bit, i.e. most urgent level
    function automatic pick_t first_set(input lvl_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = LVL_W'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t lvl_onehot(input logic [LVL_W-1:0] idx);
        lvl_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/evt_latch.sv
module evt_latch
    import evt_pkg::*;
#(
    parameter lvl_vec_t RST_PEND = lvl_onehot(LV_RST)
) (
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t req_i,
    input  lvl_vec_t clr_i,
    output lvl_vec_t pend_o
);
    lvl_vec_t req_q;
    lvl_vec_t pend_q;
    lvl_vec_t rise;

    assign rise = req_i & ~req_q;

    // sample history also during reset so a line held high is not seen as an edge
    always_ff @(posedge clk) begin
        req_q <= req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= RST_PEND;
        end else begin
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/evt_resolve.sv
module evt_resolve
    import evt_pkg::*;
(
    input  lvl_vec_t         pend_i,
    input  lvl_vec_t         en_i,
    input  lvl_vec_t         act_i,
    output logic             grant_o,
    output logic [LVL_W-1:0] lvl_o,
    output lvl_vec_t         oh_o
);
    pick_t cand;
    pick_t busy;

    always_comb begin
        cand    = first_set(pend_i & en_i);
        busy    = first_set(act_i);
        grant_o = cand.hit && (!busy.hit || (cand.idx < busy.idx));
        lvl_o   = cand.idx;
        oh_o    = grant_o ? lvl_onehot(cand.idx) : '0;
    end
endmodule

// File: rtl/evt_active.sv
module evt_active
    import evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t set_i,
    input  logic     ret_i,
    output lvl_vec_t act_o
);
    lvl_vec_t act_q;
    lvl_vec_t retired;

    // v & (v-1) drops the lowest set bit: the most urgent level in service
    assign retired = ret_i ? (act_q & (act_q - 1'b1)) : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            act_q <= retired | set_i;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
    import evt_pkg::*;
#(
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 64,
    parameter int unsigned VEC_STRIDE = 4,
    parameter lvl_vec_t    LOCKED_EN  = 16'h001F,
    parameter lvl_vec_t    RST_EN     = 16'h001F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      req_i,
    input  logic             mask_wr_i,
    input  logic [15:0]      mask_i,
    input  logic             ret_i,
    output logic             take_o,
    output logic [3:0]       take_lvl_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [15:0]      pend_o,
    output logic [15:0]      act_o
);
    localparam lvl_vec_t EN_AT_RST = RST_EN | LOCKED_EN;

    lvl_vec_t         mask_q;
    lvl_vec_t         pend;
    lvl_vec_t         act;
    lvl_vec_t         gnt_oh;
    logic             gnt;
    logic [LVL_W-1:0] gnt_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= EN_AT_RST;
        end else if (mask_wr_i) begin
            mask_q <= mask_i | LOCKED_EN;
        end
    end

    evt_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (gnt_oh),
        .pend_o (pend)
    );

    evt_resolve u_resolve (
        .pend_i  (pend),
        .en_i    (mask_q),
        .act_i   (act),
        .grant_o (gnt),
        .lvl_o   (gnt_lvl),
        .oh_o    (gnt_oh)
    );

    evt_active u_active (
        .clk   (clk),
        .rst   (rst),
        .set_i (gnt_oh),
        .ret_i (ret_i),
        .act_o (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_lvl_o <= '0;
            vec_o      <= '0;
        end else begin
            take_o <= gnt;
            if (gnt) begin
                take_lvl_o <= gnt_lvl;
                vec_o      <= VEC_W'(VEC_BASE + VEC_STRIDE * int'(gnt_lvl));
            end
        end
    end

    assign pend_o = pend;
    assign act_o  = act;
endmodule

// File: rtl/evt_nest_chk.sv
module evt_nest_chk
    import evt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ret_i,
    input logic        take_o,
    input logic [3:0]  take_lvl_o,
    input logic [15:0] pend_o,
    input logic [15:0] act_o,
    input logic [15:0] mask_q
);
    logic     past_ok;
    logic     prev_ret;
    lvl_vec_t prev_pend;
    lvl_vec_t prev_act;
    lvl_vec_t prev_mask;

    always_ff @(posedge clk) begin
        past_ok   <= !rst;
        prev_ret  <= ret_i;
        prev_pend <= pend_o;
        prev_act  <= act_o;
        prev_mask <= mask_q;
    end

    assert_take_sets_active_R7: assert property (@(posedge clk) disable iff (rst)
        take_o |-> act_o[take_lvl_o]);

    assert_take_was_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && take_o) |-> prev_pend[take_lvl_o]);

    assert_take_was_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && take_o) |-> prev_mask[take_lvl_o]);

    assert_take_preempts_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && take_o) |->
            (prev_act == '0 || take_lvl_o < first_set(prev_act).idx));

    assert_return_retires_one_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && prev_ret && prev_act != '0 && !take_o) |->
            ($countones(act_o) == $countones(prev_act) - 1));

    assert_idle_return_noop_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && prev_ret && prev_act == '0 && !take_o) |-> (act_o == '0));
endmodule

bind evt_nest_ctrl evt_nest_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ret_i      (ret_i),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o),
    .pend_o     (pend_o),
    .act_o      (act_o),
    .mask_q     (mask_q)
);

// File: tb/tb_evt_nest_ctrl.sv
module tb_evt_nest_ctrl;
    logic        clk;
    logic        rst;
    logic [15:0] req_i;
    logic        mask_wr_i;
    logic [15:0] mask_i;
    logic        ret_i;
    logic        take_o;
    logic [3:0]  take_lvl_o;
    logic [7:0]  vec_o;
    logic [15:0] pend_o;
    logic [15:0] act_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    evt_nest_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .mask_wr_i  (mask_wr_i),
        .mask_i     (mask_i),
        .ret_i      (ret_i),
        .take_o     (take_o),
        .take_lvl_o (take_lvl_o),
        .vec_o      (vec_o),
        .pend_o     (pend_o),
        .act_o      (act_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic pulse_req(input logic [15:0] bits);
        req_i = bits;
        tick();
        req_i = '0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1;
        tick();
        ret_i = 1'b0;
    endtask

    task automatic set_mask(input logic [15:0] m);
        mask_wr_i = 1'b1;
        mask_i    = m;
        tick();
        mask_wr_i = 1'b0;
    endtask

    task automatic chk_take(input string tag, input int lvl);
        chk({tag, " take"}, 32'(take_o), 32'd1);
        chk({tag, " lvl"}, 32'(take_lvl_o), 32'(lvl));
        chk({tag, " vec"}, 32'(vec_o), 32'(64 + 4 * lvl));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_i = '0; mask_wr_i = 1'b0; mask_i = '0; ret_i = 1'b0;
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 pend", 32'(pend_o), 32'h0002);
        chk("R1 act", 32'(act_o), 32'h0);
        chk("R1 take", 32'(take_o), 32'h0);
        tick();
        chk_take("R1 R7 reset level", 1);
        chk("R7 act after reset take", 32'(act_o), 32'h0002);
        do_ret();
        chk("R8 act after return", 32'(act_o), 32'h0);

        // R1: level 5 disabled after reset, level 4 enabled
        pulse_req(16'h0020);
        tick(); tick();
        chk("R1 lvl5 held", 32'(take_o), 32'h0);
        chk("R1 lvl5 pend", 32'(pend_o), 32'h0020);
        pulse_req(16'h0010);
        tick();
        chk_take("R1 lvl4 enabled", 4);
        do_ret();
        set_mask(16'hFFFF);
        tick();
        chk_take("R4 lvl5 after enable", 5);
        do_ret();
        tick();

        // R2 R7: every level alone
        for (int n = 0; n < 16; n++) begin
            req_i = 16'(1 << n);
            tick();
            req_i = '0;
            chk("R2 pend set", 32'(pend_o), 32'(1 << n));
            chk("R7 no take yet", 32'(take_o), 32'h0);
            tick();
            chk_take("R7 single", n);
            chk("R7 act", 32'(act_o), 32'(1 << n));
            chk("R7 pend cleared", 32'(pend_o), 32'h0);
            do_ret();
            chk("R8 act clear", 32'(act_o), 32'h0);
        end

        // R3 R6 R8: every pair raised together
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                pulse_req(16'((1 << a) | (1 << b)));
                tick();
                chk_take("R3 winner", a);
                chk("R3 loser pend", 32'(pend_o), 32'(1 << b));
                tick();
                chk("R6 lower waits", 32'(take_o), 32'h0);
                do_ret();
                tick();
                chk_take("R8 resume next", b);
                do_ret();
                tick();
            end
        end

        // R6 R8: nesting and preemption
        pulse_req(16'h0400);
        tick();
        chk_take("R6 base lvl10", 10);
        pulse_req(16'h1000);
        tick(); tick();
        chk("R6 lvl12 blocked", 32'(take_o), 32'h0);
        chk("R6 lvl12 pend", 32'(pend_o), 32'h1000);
        pulse_req(16'h0040);
        tick();
        chk_take("R6 preempt lvl6", 6);
        chk("R6 nested act", 32'(act_o), 32'h0440);
        do_ret();
        chk("R8 resume lvl10", 32'(act_o), 32'h0400);
        tick();
        chk("R6 lvl12 still blocked", 32'(take_o), 32'h0);
        do_ret();
        chk("R8 act empty", 32'(act_o), 32'h0);
        tick();
        chk_take("R6 lvl12 granted", 12);
        // equal level waits
        pulse_req(16'h1000);
        tick();
        chk("R6 equal waits", 32'(take_o), 32'h0);
        chk("R6 equal pend", 32'(pend_o), 32'h1000);
        do_ret();
        tick();
        chk_take("R6 equal after return", 12);
        do_ret();
        tick();

        // R4 R5: mask write of zeros
        set_mask(16'h0000);
        pulse_req(16'h0100);
        tick(); tick();
        chk("R4 masked no take", 32'(take_o), 32'h0);
        chk("R4 masked pend", 32'(pend_o), 32'h0100);
        pulse_req(16'h0004);
        tick();
        chk_take("R5 nmi unmaskable", 2);
        do_ret();
        pulse_req(16'h0001);
        tick();
        chk_take("R5 lvl0 unmaskable", 0);
        do_ret();
        set_mask(16'hFFFF);
        tick();
        chk_take("R4 unmasked", 8);
        do_ret();
        tick();

        // R2: held request latched once
        req_i = 16'h0800;
        tick(); tick();
        chk_take("R2 held", 11);
        do_ret();
        tick(); tick();
        chk("R2 no retake", 32'(take_o), 32'h0);
        chk("R2 no repend", 32'(pend_o), 32'h0);
        req_i = '0;
        tick();

        // R9: return with nothing active
        do_ret();
        chk("R9 act", 32'(act_o), 32'h0);
        chk("R9 pend", 32'(pend_o), 32'h0);
        chk("R9 take", 32'(take_o), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule